// File: doc/BRIEF.md
# Lane-Partitioned Packed Adder

This block is a 64-bit integer adder whose carry chain can be cut into independent lanes at run time. A two-bit mode input picks the lane width: a single 64-bit lane, two 32-bit lanes, four 16-bit lanes or eight 8-bit lanes. Each operation adds, or subtracts, every lane of two packed operands in the same cycle. Every lane is active on every operation: there is no per-lane enable and no way to limit how many lanes take part.

The datapath is built from eight 8-bit segments. A segment that starts a lane takes its carry-in from the operation type: 0 for add, 1 for subtract. Every other segment takes the carry-out of the segment below it. Subtraction inverts operand B before the adders and injects a carry-in of 1 at the bottom of each lane. The packed result and one carry flag per segment are registered, so results appear one cycle after the operation is presented.

Top module: `simd_add_unit`

## Requirements
- R1: While reset (rstN low) is asserted, result, carryFlags and validOut are all zero.
- R2: With laneMode = 2'b00 the block computes one 64-bit sum or difference, modulo 2^64.
- R3: With laneMode = 2'b01, 2'b10 or 2'b11 the operands are split into 32-, 16- or 8-bit lanes. Lane k occupies bits [k*w+w-1 : k*w]. Each lane wraps modulo 2^w, and no carry passes from one lane into the next.
- R4: With subIn = 1, every lane yields A minus B modulo 2^w, computed as A + ~B + 1 within that lane.
- R5: carryFlags bit j belongs to bits [8j+7 : 8j]. At the segment holding the top of a lane, the bit is the carry-out of that lane's add. For subtraction this is 1 when the lane of A is at least the lane of B (unsigned). All other carryFlags bits read 0.
- R6: validOut equals validIn of the previous clock. result and carryFlags show the operation that was presented at that edge.
- R7: A clock edge with validIn low leaves result and carryFlags unchanged, whatever the operands, mode and subIn are.
- R8: laneMode and subIn can change on consecutive operations, and each operation uses only its own mode and operation type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Operation strobe |
| subIn | input | 1 | 1 selects subtract, 0 selects add |
| laneMode | input | 2 | Lane width: 00=64, 01=32, 10=16, 11=8 bits |
| opA | input | 64 | Packed operand A |
| opB | input | 64 | Packed operand B |
| result | output | 64 | Registered packed result |
| carryFlags | output | 8 | Registered carry flag for each 8-bit segment |
| validOut | output | 1 | validIn delayed by one cycle |

## Verification
The bench aims all-ones plus one at every lane width. If the carry chain were not cut at a lane edge, the overflow would spill into the next lane and leave a 1 there instead of 0. Equal-operand and zero-minus-one subtractions exercise the per-lane carry injection: with the injection missing from any lane but the lowest, that lane would come out off by one and its flag would be wrong. The bench also checks that flags below the top of a lane stay zero, that edges with validIn low leave the result unchanged, and that modes can alternate on back-to-back operations without one operation's lane cuts reaching the next.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
  localparam int SEG_W     = 8;
  localparam int SEG_CNT   = 8;
  localparam int DATA_W    = SEG_W * SEG_CNT;
  localparam int MODE_W    = 2;
  localparam int SEG_IDX_W = $clog2(SEG_CNT);

  typedef struct packed {
    logic               opValid;
    logic               opSub;
    logic [SEG_CNT-1:0] laneStart;
    logic [SEG_CNT-1:0] laneTop;
  } addStrobes_t;
endpackage

// File: rtl/simd_add_ctrl.sv
module simd_add_ctrl
  import simd_add_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic              subIn,
  input  logic [MODE_W-1:0] laneMode,
  output addStrobes_t       strobes
);
  logic [SEG_IDX_W:0]   segsPerLane;
  logic [SEG_IDX_W-1:0] laneIdxMask;
  logic [SEG_CNT-1:0]   startVec;
  logic [SEG_CNT-1:0]   topVec;

  always_comb begin
    segsPerLane = (SEG_IDX_W+1)'(SEG_CNT) >> laneMode;
    laneIdxMask = SEG_IDX_W'(segsPerLane - 1'b1);
  end

  for (genvar s = 0; s < SEG_CNT; s++) begin : g_bound
    localparam logic [SEG_IDX_W-1:0] SIDX = SEG_IDX_W'(s);
    assign startVec[s] = ((SIDX & laneIdxMask) == '0);
    assign topVec[s]   = ((SIDX & laneIdxMask) == laneIdxMask);
  end

  always_comb begin
    strobes.opValid   = validIn;
    strobes.opSub     = subIn;
    strobes.laneStart = startVec;
    strobes.laneTop   = topVec;
  end

  // Lowest segment always opens a lane, highest always closes one (R3)
  p_low_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    startVec[0] && topVec[SEG_CNT-1]);

  // A lane top is always followed by a lane start (R3)
  for (genvar s = 0; s < SEG_CNT-1; s++) begin : g_chk
    p_edge_pair_r3: assert property (@(posedge clk) disable iff (!rstN)
      startVec[s+1] == topVec[s]);
  end

  // Number of lane tops matches the requested lane count (R5)
  p_top_count_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(topVec) == (1 << laneMode));
endmodule

// File: rtl/simd_add_dp.sv
module simd_add_dp
  import simd_add_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  addStrobes_t       strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic [SEG_CNT-1:0] carryFlags,
  output logic              validOut
);
  logic [DATA_W-1:0]  sumWord;
  logic [SEG_CNT-1:0] coutVec;

  for (genvar s = 0; s < SEG_CNT; s++) begin : g_seg
    logic [SEG_W-1:0] aSeg;
    logic [SEG_W-1:0] bSeg;
    logic             segCin;
    logic             segCout;
    assign aSeg = opA[s*SEG_W +: SEG_W];
    assign bSeg = strobes.opSub ? ~opB[s*SEG_W +: SEG_W] : opB[s*SEG_W +: SEG_W];
    if (s == 0) begin : g_first
      assign segCin = strobes.opSub;
    end else begin : g_rest
      assign segCin = strobes.laneStart[s] ? strobes.opSub : g_seg[s-1].segCout;
    end
    assign {segCout, sumWord[s*SEG_W +: SEG_W]} =
      {1'b0, aSeg} + {1'b0, bSeg} + {{SEG_W{1'b0}}, segCin};
    assign coutVec[s] = segCout;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result     <= '0;
      carryFlags <= '0;
      validOut   <= 1'b0;
    end else begin
      validOut <= strobes.opValid;
      if (strobes.opValid) begin
        result     <= sumWord;
        carryFlags <= coutVec & strobes.laneTop;
      end
    end
  end

  // validOut follows validIn by one cycle (R6)
  p_valid_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.opValid |=> validOut);
  p_valid_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.opValid |=> !validOut);

  // Idle edge keeps result and flags (R7)
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.opValid |=> ($stable(result) && $stable(carryFlags)));

  // x - x is zero in every lane with a carry at each lane top (R4)
  p_self_sub_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.opValid && strobes.opSub && opA == opB)
      |=> (result == '0 && carryFlags == $past(strobes.laneTop)));

  // Adding zero returns A unchanged with no carries (R3)
  p_add_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.opValid && !strobes.opSub && opB == '0)
      |=> (result == $past(opA) && carryFlags == '0));
endmodule

// File: rtl/simd_add_unit.sv
module simd_add_unit
  import simd_add_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               validIn,
  input  logic               subIn,
  input  logic [MODE_W-1:0]  laneMode,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  output logic [DATA_W-1:0]  result,
  output logic [SEG_CNT-1:0] carryFlags,
  output logic               validOut
);
  addStrobes_t strobes;

  simd_add_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .subIn    (subIn),
    .laneMode (laneMode),
    .strobes  (strobes)
  );

  simd_add_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .opA        (opA),
    .opB        (opB),
    .result     (result),
    .carryFlags (carryFlags),
    .validOut   (validOut)
  );
endmodule

// File: tb/simd_add_unit_bench.sv
module simd_add_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic        subIn = 1'b0;
  logic [1:0]  laneMode = 2'b00;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [63:0] result;
  logic [7:0]  carryFlags;
  logic        validOut;

  int checks = 0;
  int fails  = 0;
  logic [63:0] expRes = '0;
  logic [7:0]  expFl  = '0;

  always #5 clk = ~clk;

  simd_add_unit u_simd_add_unit (
    .clk(clk), .rstN(rstN), .validIn(validIn), .subIn(subIn),
    .laneMode(laneMode), .opA(opA), .opB(opB),
    .result(result), .carryFlags(carryFlags), .validOut(validOut)
  );

  function automatic logic [71:0] refOp(logic [63:0] a, logic [63:0] b,
                                        logic [1:0] m, logic s);
    int w = 64 >> m;
    int lanes = 1 << m;
    logic [63:0] res = '0;
    logic [7:0]  fl = '0;
    logic [64:0] mask = (65'd1 << w) - 65'd1;
    for (int l = 0; l < lanes; l++) begin
      logic [64:0] av;
      logic [64:0] bv;
      logic [64:0] sm;
      av = ({1'b0, a} >> (l * w)) & mask;
      bv = ({1'b0, b} >> (l * w)) & mask;
      if (s) bv = (~bv) & mask;
      sm = av + bv + {64'd0, s};
      res = res | 64'((sm & mask) << (l * w));
      fl[(l * w + w) / 8 - 1] = sm[w];
    end
    return {fl, res};
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(logic [63:0] a, logic [63:0] b, logic [1:0] m,
                      logic s, logic v, string tag);
    string rt;
    opA = a; opB = b; laneMode = m; subIn = s; validIn = v;
    if (v) {expFl, expRes} = refOp(a, b, m, s);
    @(negedge clk);
    if (tag != "") rt = tag;
    else if (!v) rt = "R7";
    else if (s) rt = "R4";
    else if (m == 2'b00) rt = "R2";
    else rt = "R3";
    chk(rt, result, expRes);
    chk(v ? "R5" : "R7", {56'd0, carryFlags}, {56'd0, expFl});
    chk("R6", {63'd0, validOut}, {63'd0, v});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    validIn = 1'b1; opA = '1; opB = 64'd1;
    repeat (3) @(negedge clk);
    chk("R1", result, 64'd0);
    chk("R1", {56'd0, carryFlags}, 64'd0);
    chk("R1", {63'd0, validOut}, 64'd0);
    rstN = 1'b1;
    validIn = 1'b0;
    @(negedge clk);

    step('1, 64'd1, 2'b00, 1'b0, 1'b1, "R2");
    step('1, 64'h0101_0101_0101_0101, 2'b11, 1'b0, 1'b1, "R3");
    step(64'h0000_0000_FFFF_FFFF, 64'd1, 2'b01, 1'b0, 1'b1, "R3");
    step(64'h7FFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 2'b10, 1'b0, 1'b1, "R3");
    step(64'd0, 64'h0001_0001_0001_0001, 2'b10, 1'b1, 1'b1, "R4");
    step(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 2'b11, 1'b1, 1'b1, "R4");
    step(64'd0, 64'd1, 2'b00, 1'b1, 1'b1, "R4");
    step(64'h55AA_0000_FFFF_8000, 64'h1234_5678, 2'b01, 1'b0, 1'b0, "R7");
    step(64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080, 2'b11, 1'b0, 1'b1, "R5");
    step(64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080, 2'b00, 1'b0, 1'b1, "R8");
    step(64'h8080_8080_8080_8080, 64'h0080_0080_0080_0081, 2'b10, 1'b1, 1'b1, "R8");
    step(64'hFF00_FF00_FF00_FF00, 64'h0100_0100_0100_0100, 2'b01, 1'b0, 1'b1, "R8");

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a;
      logic [63:0] b;
      int pick;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      pick = $urandom_range(0, 7);
      if (pick == 0) b = ~a;
      if (pick == 1) b = a;
      if (pick == 2) a = '1;
      step(a, b, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 4) != 0), "");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule